// File: doc/BRIEF.md
# Codeword Sync Hunter

This block follows receive-side alignment to a sync marker that repeats once per codeword in a framed DSL transport stream. The pattern detector upstream reports one verdict per codeword slot: a strobe marks the slot, and a flag says whether the marker was found (hit) or not (miss). From these verdicts the block runs a four-state machine. It hunts for the marker, confirms it, holds lock, and rides through isolated misses in two freewheel states before it gives up.

The current state is presented as a 2-bit code. A single status bit, suitable for reporting to the far end, is high while the receiver counts as synced. Two 16-bit thresholds of consecutive misses can be written at run time. The first decides when the unconfirmed freewheel state falls back to hunting. The second decides when the locked freewheel state is demoted to the unconfirmed one. Both thresholds are visible on output ports. Reset is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `sync_hunt`

## Requirements
- R1: While reset is held and after it is released, the state code is 0, the synced bit is 0, the fall-back threshold reads 3 and the demote threshold reads 7.
- R2: State codes on `lock_state` are: 0 hunting, 1 freewheel-unconfirmed, 2 locked, 3 freewheel-held. The code updates on the clock edge that samples a slot and is visible after that edge.
- R3: In hunting, a hit moves to freewheel-unconfirmed and a miss stays in hunting.
- R4: In freewheel-unconfirmed, a hit moves to locked.
- R5: In freewheel-unconfirmed, the miss that brings the run of consecutive misses counted there up to the fall-back threshold returns the machine to hunting. A threshold of 0 or 1 makes the first miss do this.
- R6: In locked, a miss moves to freewheel-held, and that miss counts as the first of the run.
- R7: In freewheel-held, a hit returns to locked.
- R8: In freewheel-held, the miss that brings the run up to the demote threshold moves to freewheel-unconfirmed. The run then restarts at zero for the fall-back threshold. With a demote threshold of 0, 1 or 2, the second miss after locked demotes.
- R9: Only consecutive misses count: any hit clears the run, so a later loss of lock again needs the full threshold.
- R10: Cycles without the slot strobe change neither the state nor the run of misses, whatever the hit flag shows.
- R11: A write with `thr_sel` = 0 loads the fall-back threshold and a write with `thr_sel` = 1 loads the demote threshold. The new value shows on its output port after the write edge and governs every later slot.
- R12: `far_synced` is 1 in locked and freewheel-held, and 0 in the other two states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 1 | One codeword slot verdict this cycle |
| slot_hit | input | 1 | 1 = sync marker found, 0 = missed (used with slot_valid) |
| thr_wr | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | 0 = fall-back threshold, 1 = demote threshold |
| thr_wdata | input | 16 | Threshold write value |
| lock_state | output | 2 | Current state code |
| far_synced | output | 1 | Synced status for the far end |
| lost_thr | output | 16 | Current fall-back threshold |
| drop_thr | output | 16 | Current demote threshold |

## Verification
The checker watches every cycle for the legal edges of the state graph. It checks that hunting is only left on a hit and never straight into lock, that a miss in lock always lands in freewheel-held with a run of one, and that a hit in either freewheel state reaches locked or the unconfirmed state as required. It also checks that the state and the run hold still without a slot strobe, and that the synced bit rises only on entry to lock. Only the directed scenarios can show how long a miss run lasts before the machine falls back, since that depends on the programmed thresholds and on where a hit broke the run. The same holds for the reset defaults and for the exact slot at which a newly written threshold starts to count.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_UNSURE = 2'd1,
    ST_LOCKED = 2'd2,
    ST_HELD   = 2'd3
  } hunt_state_t;
endpackage

// File: rtl/sh_rst_sync.sv
module sh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/sh_thr_regs.sv
module sh_thr_regs #(
  parameter int CNT_W    = 16,
  parameter int LOST_DEF = 3,
  parameter int DROP_DEF = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] lost_q,
  output logic [CNT_W-1:0] drop_q
);
  localparam logic [CNT_W-1:0] LOST_RST = CNT_W'(LOST_DEF);
  localparam logic [CNT_W-1:0] DROP_RST = CNT_W'(DROP_DEF);

  logic lost_en, drop_en;
  assign lost_en = wr && !sel;
  assign drop_en = wr &&  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lost_q <= LOST_RST;
    else if (lost_en) lost_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_q <= DROP_RST;
    else if (drop_en) drop_q <= wdata;
  end
endmodule

// File: rtl/sh_miss_cnt.sv
module sh_miss_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             set_one,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (set_one) cnt_d = CNT_W'(1);
    else if (inc)     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sh_fsm.sv
module sh_fsm
  import sync_hunt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic             slot_hit,
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic [CNT_W-1:0] lost_thr,
  input  logic [CNT_W-1:0] drop_thr,
  output hunt_state_t      state_q,
  output logic             cnt_clr,
  output logic             cnt_one,
  output logic             cnt_inc
);
  localparam int SUM_W = CNT_W + 1;

  hunt_state_t state_d;
  logic [SUM_W-1:0] run_next;
  logic lost_reached, drop_reached;

  assign run_next     = {1'b0, miss_cnt} + SUM_W'(1);
  assign lost_reached = run_next >= {1'b0, lost_thr};
  assign drop_reached = run_next >= {1'b0, drop_thr};

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_one = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        cnt_clr = 1'b1;
        if (slot_hit) state_d = ST_UNSURE;
      end
      ST_UNSURE: begin
        if (slot_hit) begin
          state_d = ST_LOCKED;
          cnt_clr = 1'b1;
        end else if (lost_reached) begin
          state_d = ST_HUNT;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (slot_hit) cnt_clr = 1'b1;
        else begin
          state_d = ST_HELD;
          cnt_one = 1'b1;
        end
      end
      ST_HELD: begin
        if (slot_hit) begin
          state_d = ST_LOCKED;
          cnt_clr = 1'b1;
        end else if (drop_reached) begin
          state_d = ST_UNSURE;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: begin
        state_d = ST_HUNT;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= ST_HUNT;
    else if (slot_valid) state_q <= state_d;
  end
endmodule

// File: rtl/sync_hunt.sv
module sync_hunt
  import sync_hunt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOST_DEF = 3,
  parameter int DROP_DEF = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic             slot_hit,
  input  logic             thr_wr,
  input  logic             thr_sel,
  input  logic [CNT_W-1:0] thr_wdata,
  output logic [1:0]       lock_state,
  output logic             far_synced,
  output logic [CNT_W-1:0] lost_thr,
  output logic [CNT_W-1:0] drop_thr
);
  logic             rst_q_n;
  logic [CNT_W-1:0] miss_cnt;
  logic             cnt_clr, cnt_one, cnt_inc;
  hunt_state_t      state_q;

  sh_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sh_thr_regs #(.CNT_W(CNT_W), .LOST_DEF(LOST_DEF), .DROP_DEF(DROP_DEF)) u_thr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr     (thr_wr),
    .sel    (thr_sel),
    .wdata  (thr_wdata),
    .lost_q (lost_thr),
    .drop_q (drop_thr)
  );

  sh_miss_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .en      (slot_valid),
    .clr     (cnt_clr),
    .set_one (cnt_one),
    .inc     (cnt_inc),
    .cnt_q   (miss_cnt)
  );

  sh_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .slot_valid (slot_valid),
    .slot_hit   (slot_hit),
    .miss_cnt   (miss_cnt),
    .lost_thr   (lost_thr),
    .drop_thr   (drop_thr),
    .state_q    (state_q),
    .cnt_clr    (cnt_clr),
    .cnt_one    (cnt_one),
    .cnt_inc    (cnt_inc)
  );

  assign lock_state = state_q;
  assign far_synced = (state_q == ST_LOCKED) || (state_q == ST_HELD);
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             slot_valid,
  input logic             slot_hit,
  input logic [1:0]       lock_state,
  input logic             far_synced,
  input logic [CNT_W-1:0] miss_cnt
);
  // R3: hunting left only on a hit, and only towards the unconfirmed state
  assert_hunt_hit_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && slot_hit && lock_state == 2'd0) |=> lock_state == 2'd1);
  assert_hunt_miss_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && !slot_hit && lock_state == 2'd0) |=> lock_state == 2'd0);
  // R4
  assert_unsure_hit_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && slot_hit && lock_state == 2'd1) |=> lock_state == 2'd2);
  // R6
  assert_locked_miss_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && !slot_hit && lock_state == 2'd2) |=> (lock_state == 2'd3 && miss_cnt == CNT_W'(1)));
  // R7 and R9
  assert_held_hit_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && slot_hit && lock_state == 2'd3) |=> (lock_state == 2'd2 && miss_cnt == '0));
  // R8: freewheel-held never falls straight back to hunting
  assert_held_exit_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (slot_valid && !slot_hit && lock_state == 2'd3) |=> lock_state != 2'd0);
  // R10
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !slot_valid |=> ($stable(lock_state) && $stable(miss_cnt)));
  // R12: synced bit rises only on entry to lock from the unconfirmed state
  assert_sync_rise_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(far_synced) |-> (lock_state == 2'd2 && $past(lock_state) == 2'd1));
endmodule

bind sync_hunt sync_hunt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .slot_valid (slot_valid),
  .slot_hit   (slot_hit),
  .lock_state (lock_state),
  .far_synced (far_synced),
  .miss_cnt   (miss_cnt)
);

// File: tb/tb_sync_hunt.sv
module tb_sync_hunt;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_valid = 1'b0, slot_hit = 1'b0;
  logic thr_wr = 1'b0, thr_sel = 1'b0;
  logic [W-1:0] thr_wdata = '0;
  logic [1:0] lock_state;
  logic far_synced;
  logic [W-1:0] lost_thr, drop_thr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_hit(slot_hit),
    .thr_wr(thr_wr), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
    .lock_state(lock_state), .far_synced(far_synced),
    .lost_thr(lost_thr), .drop_thr(drop_thr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_valid = 1'b0; thr_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic slot(input logic hit);
    @(negedge clk);
    slot_valid = 1'b1; slot_hit = hit;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  task automatic misses(input int n);
    for (int i = 0; i < n; i++) slot(1'b0);
  endtask

  task automatic wr_thr(input logic sel, input int val);
    @(negedge clk);
    thr_wr = 1'b1; thr_sel = sel; thr_wdata = W'(val);
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 state in reset", lock_state, 0);
    do_reset();
    chk("R1 state", lock_state, 0);
    chk("R1 synced", far_synced, 0);
    chk("R1 lost default", lost_thr, 3);
    chk("R1 drop default", drop_thr, 7);
  endtask

  task automatic t_hunt();
    do_reset();
    misses(3);
    chk("R3 miss stays hunting", lock_state, 0);
    slot(1'b1);
    chk("R3 R2 hit -> unsure code 1", lock_state, 1);
    chk("R12 unsure not synced", far_synced, 0);
  endtask

  task automatic t_unsure();
    do_reset();
    slot(1'b1);
    misses(2);
    chk("R5 two misses stay unsure", lock_state, 1);
    slot(1'b0);
    chk("R5 third miss -> hunting", lock_state, 0);
    slot(1'b1); misses(2); slot(1'b1);
    chk("R4 R2 hit -> locked code 2", lock_state, 2);
    chk("R12 locked synced", far_synced, 1);
  endtask

  task automatic t_demote();
    do_reset();
    slot(1'b1); slot(1'b1);
    slot(1'b0);
    chk("R6 R2 miss -> held code 3", lock_state, 3);
    chk("R12 held synced", far_synced, 1);
    misses(5);
    chk("R8 six misses still held", lock_state, 3);
    slot(1'b0);
    chk("R8 seventh miss -> unsure", lock_state, 1);
    chk("R12 synced drops", far_synced, 0);
    misses(2);
    chk("R8 run restarted in unsure", lock_state, 1);
    slot(1'b0);
    chk("R8 R5 third miss -> hunting", lock_state, 0);
  endtask

  task automatic t_recover();
    do_reset();
    slot(1'b1); slot(1'b1);
    misses(6);
    slot(1'b1);
    chk("R7 hit in held -> locked", lock_state, 2);
    misses(6);
    chk("R9 run cleared by hit", lock_state, 3);
    slot(1'b0);
    chk("R9 full run demotes", lock_state, 1);
  endtask

  task automatic t_idle();
    do_reset();
    slot(1'b1); slot(1'b1); misses(6);
    @(negedge clk);
    slot_hit = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 idle keeps held", lock_state, 3);
    slot_hit = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 idle hit ignored", lock_state, 3);
    slot(1'b0);
    chk("R10 run kept over idle", lock_state, 1);
  endtask

  task automatic t_thresholds();
    do_reset();
    wr_thr(1'b0, 5);
    wr_thr(1'b1, 2);
    chk("R11 lost readback", lost_thr, 5);
    chk("R11 drop readback", drop_thr, 2);
    slot(1'b1); misses(4);
    chk("R11 four misses under 5", lock_state, 1);
    slot(1'b0);
    chk("R11 R5 fifth miss -> hunting", lock_state, 0);
    slot(1'b1); slot(1'b1); slot(1'b0);
    chk("R11 held after one miss", lock_state, 3);
    slot(1'b0);
    chk("R11 R8 drop 2 -> unsure", lock_state, 1);
    wr_thr(1'b0, 0);
    slot(1'b0);
    chk("R5 threshold 0 first miss", lock_state, 0);
    wr_thr(1'b1, 1);
    wr_thr(1'b0, 1);
    slot(1'b1); slot(1'b0);
    chk("R5 threshold 1 first miss", lock_state, 0);
    slot(1'b1); slot(1'b1); slot(1'b0);
    chk("R8 drop 1 held first", lock_state, 3);
    slot(1'b0);
    chk("R8 drop 1 second miss", lock_state, 1);
  endtask

  initial begin
    t_reset();
    t_hunt();
    t_unsure();
    t_demote();
    t_recover();
    t_idle();
    t_thresholds();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule